// File: doc/BRIEF.md
# Bit-Band Alias Bridge

This block is a memory-mapped slave that sits in front of a byte-addressable backing memory port and presents a 32 MB alias window. Every 32-bit word in that window stands for a single bit of the backing memory. A read of an alias word fetches the backing unit that contains the bit and returns only that bit in bit 0 of the response. A write to an alias word performs a read-modify-write. The bridge fetches the unit, forces the selected bit to bit 0 of the write data, and stores the unit back at the same address and size.

The alias side uses a simple request/response handshake. A request is taken when `req_valid` and `req_ready` are both high, and the answer comes back as a one-cycle `rsp_valid` pulse. The backing side is a master port with a request handshake and a one-cycle response strobe. The backing base address is a parameter, so one instance serves each bit-band region, for example 0x20000000 or 0x40000000.

The whole alias access is atomic as seen from the alias port. No new request is taken until the final backing response of the current one has returned. Data on the backing port is little-endian and right-justified: byte k of a unit travels on bits 8k+7 to 8k.

Top module: `bitband_bridge`

## Requirements
- R1: The backing address is `BASE_ADDR | (req_addr[24:0] >> 5)`, rounded down to a multiple of the access size. Alias address bits 25 and above have no effect.
- R2: The selected bit index is `req_addr[6:2]` modulo `8*size`. With little-endian right-justified data this is bit `index` of the backing unit: byte `index/8`, bit `index%8`.
- R3: An alias read issues exactly one backing read and no backing write. It answers with the selected bit in `rsp_rdata[0]`, bits 31..1 zero, and `rsp_err` low.
- R4: An alias write issues one backing read and then one backing write, both with the same address and size. The written unit equals the fetched unit with the selected bit replaced by `req_wdata[0]`. Bits 31..1 of `req_wdata` have no effect.
- R5: If the backing read returns `mem_rsp_err` high, the alias response has `rsp_err` high and no backing write is issued.
- R6: The error status of the write-back response is passed unchanged to `rsp_err`.
- R7: A request whose `req_size` is not 1, 2 or 4 (byte count encoding) is answered with `rsp_err` high on the cycle after acceptance, and no backing access is made.
- R8: `req_ready` stays low from acceptance until the response cycle ends. Each accepted request gets exactly one `rsp_valid` pulse, one cycle long.
- R9: After a synchronous active-low reset the block is idle: `req_ready` is high, `mem_req_valid` is low and `rsp_valid` is low.
- R10: While `mem_req_valid` is high and `mem_req_ready` is low, the backing request (address, size, direction, write data) is held stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Alias request present |
| req_ready | output | 1 | Bridge idle, request taken this cycle if valid |
| req_write | input | 1 | 1 = alias write, 0 = alias read |
| req_addr | input | ADDR_W | Alias byte address (low 25 bits decoded) |
| req_size | input | 3 | Access size in bytes (1, 2 or 4 legal) |
| req_wdata | input | 32 | Write data, bit 0 is the new bit value |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_err | output | 1 | Response carries an error |
| rsp_rdata | output | 32 | Read result, selected bit in bit 0 |
| mem_req_valid | output | 1 | Backing request present |
| mem_req_ready | input | 1 | Backing memory takes the request |
| mem_write | output | 1 | Backing request is a write |
| mem_addr | output | ADDR_W | Backing byte address, size-aligned |
| mem_size | output | 3 | Backing access size in bytes |
| mem_wdata | output | 32 | Backing write unit, right-justified |
| mem_rsp_valid | input | 1 | Backing response strobe |
| mem_rsp_err | input | 1 | Backing response error |
| mem_rsp_rdata | input | 32 | Backing read unit, right-justified |

## Verification
The bench builds the bridge with `BASE_ADDR` = 0x20000000 and the default 32-bit address. It backs the bridge with a 64-byte memory model that is indexed by the low six address bits. This small memory lets the bench sweep all 128 alias words that map onto the first 16 backing bytes, at each of the three legal sizes, for reads and for writes of both bit values. Every bit position of every size, and the alignment drop of address bits, are therefore covered, and each write is checked against the full shadow memory. Further checks vary the alias address bits above the window and decode the top of the window. They also inject read and write-back errors, offer every illegal size, and throttle `mem_req_ready` to hold requests in a stall.

// File: rtl/bb_pkg.sv
// Package: shared state encoding and size helpers for the bit-band alias bridge.
// Assumes sizes are carried as a plain byte count in a 3-bit field.
package bb_pkg;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_RD_REQ  = 3'd1,
        ST_RD_WAIT = 3'd2,
        ST_WR_REQ  = 3'd3,
        ST_WR_WAIT = 3'd4,
        ST_RESP    = 3'd5
    } bb_state_t;

    // True for the byte counts the bridge supports.
    function automatic logic size_ok(input logic [2:0] sz);
        return (sz == 3'd1) || (sz == 3'd2) || (sz == 3'd4);
    endfunction

endpackage

// File: rtl/bb_addr_map.sv
// Module: bb_addr_map
// Turns an alias address and access size into the size-aligned backing
// address and the bit index inside the fetched unit.
// Assumes the size is already legal (1, 2 or 4); other values act as 1.
module bb_addr_map #(
    parameter int              ADDR_W    = 32,
    parameter int              WIN_BITS  = 25,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 32'h2000_0000,
    parameter int              IDX_W     = 5
) (
    input  logic [ADDR_W-1:0] alias_addr,
    input  logic [2:0]        acc_size,
    output logic [ADDR_W-1:0] back_addr,
    output logic [IDX_W-1:0]  bit_idx
);
    localparam int WORD_SHIFT = 5;

    logic [WIN_BITS-1:0] win_off;
    logic [ADDR_W-1:0]   raw_addr;
    logic [IDX_W-1:0]    idx_full;

    // Window offset and unaligned backing byte address.
    always_comb begin
        win_off  = alias_addr[WIN_BITS-1:0];
        raw_addr = BASE_ADDR | ADDR_W'(win_off >> WORD_SHIFT);
        idx_full = win_off[IDX_W+1:2];
    end

    // Align to the access size and restrict the bit index to the unit width.
    always_comb begin
        case (acc_size)
            3'd2: begin
                back_addr = {raw_addr[ADDR_W-1:1], 1'b0};
                bit_idx   = idx_full & IDX_W'(15);
            end
            3'd4: begin
                back_addr = {raw_addr[ADDR_W-1:2], 2'b00};
                bit_idx   = idx_full;
            end
            default: begin
                back_addr = raw_addr;
                bit_idx   = idx_full & IDX_W'(7);
            end
        endcase
    end

endmodule

// File: rtl/bb_bit_ops.sv
// Module: bb_bit_ops
// Picks one bit out of a fetched backing unit and builds the updated unit
// for a write-back. Assumes little-endian, right-justified unit data, so
// bit index i is simply data bit i; bytes beyond the size are cleared.
module bb_bit_ops #(
    parameter int DATA_W = 32,
    parameter int IDX_W  = 5
) (
    input  logic [DATA_W-1:0] unit_in,
    input  logic [IDX_W-1:0]  bit_idx,
    input  logic [2:0]        acc_size,
    input  logic              new_bit,
    output logic              bit_out,
    output logic [DATA_W-1:0] unit_out
);
    localparam int NBYTES = DATA_W / 8;

    logic [DATA_W-1:0] size_mask;

    // Byte-lane mask: one generate slice per lane, live when lane < size.
    for (genvar g = 0; g < NBYTES; g++) begin : g_lane
        assign size_mask[8*g +: 8] = (g < int'(acc_size)) ? 8'hFF : 8'h00;
    end

    // Extract the selected bit and merge the new value into the unit.
    always_comb begin
        logic [DATA_W-1:0] masked;
        masked  = unit_in & size_mask;
        bit_out = masked[bit_idx];
        unit_out = masked;
        unit_out[bit_idx] = new_bit;
    end

endmodule

// File: rtl/bb_ctrl.sv
// Module: bb_ctrl
// Sequencer for one alias access: accept, backing read, optional
// write-back, response. Holds the alias port busy for the whole sequence.
// Assumes the backing memory returns exactly one response per request.
module bb_ctrl
    import bb_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [2:0]        req_size,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic              rsp_err,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic              mem_write,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_rsp_valid,
    input  logic              mem_rsp_err,
    output logic [ADDR_W-1:0] lat_addr,
    output logic [2:0]        lat_size,
    output logic              lat_bit,
    input  logic              sel_bit,
    input  logic [DATA_W-1:0] merged_unit
);
    bb_state_t         state;
    logic              lat_write;
    logic [DATA_W-1:0] unit_q;
    logic              err_q;
    logic              bit_q;

    // Sequencer state and latched request fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            lat_write <= 1'b0;
            lat_addr  <= '0;
            lat_size  <= 3'd1;
            lat_bit   <= 1'b0;
            unit_q    <= '0;
            err_q     <= 1'b0;
            bit_q     <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (req_valid) begin
                        lat_write <= req_write;
                        lat_addr  <= req_addr;
                        lat_size  <= req_size;
                        lat_bit   <= req_wdata[0];
                        bit_q     <= 1'b0;
                        if (size_ok(req_size)) begin
                            err_q <= 1'b0;
                            state <= ST_RD_REQ;
                        end else begin
                            err_q <= 1'b1;
                            state <= ST_RESP;
                        end
                    end
                end
                ST_RD_REQ: if (mem_req_ready) state <= ST_RD_WAIT;
                ST_RD_WAIT: begin
                    if (mem_rsp_valid) begin
                        if (mem_rsp_err) begin
                            err_q <= 1'b1;
                            state <= ST_RESP;
                        end else if (lat_write) begin
                            unit_q <= merged_unit;
                            state  <= ST_WR_REQ;
                        end else begin
                            bit_q <= sel_bit;
                            state <= ST_RESP;
                        end
                    end
                end
                ST_WR_REQ: if (mem_req_ready) state <= ST_WR_WAIT;
                ST_WR_WAIT: begin
                    if (mem_rsp_valid) begin
                        err_q <= mem_rsp_err;
                        state <= ST_RESP;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Port outputs decoded from the state and held registers.
    always_comb begin
        req_ready     = (state == ST_IDLE);
        mem_req_valid = (state == ST_RD_REQ) || (state == ST_WR_REQ);
        mem_write     = (state == ST_WR_REQ);
        mem_wdata     = unit_q;
        rsp_valid     = (state == ST_RESP);
        rsp_err       = err_q;
        rsp_rdata     = {{(DATA_W-1){1'b0}}, bit_q};
    end

endmodule

// File: rtl/bitband_bridge.sv
// Module: bitband_bridge (top)
// Alias-window slave that maps each 32-bit alias word onto one bit of a
// backing memory, doing reads by bit extraction and writes by a sized
// read-modify-write. Assumes a little-endian backing port with
// right-justified unit data and one response per backing request.
module bitband_bridge #(
    parameter int                ADDR_W    = 32,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 32'h2000_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [2:0]        req_size,
    input  logic [31:0]       req_wdata,
    output logic              rsp_valid,
    output logic              rsp_err,
    output logic [31:0]       rsp_rdata,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic              mem_write,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [2:0]        mem_size,
    output logic [31:0]       mem_wdata,
    input  logic              mem_rsp_valid,
    input  logic              mem_rsp_err,
    input  logic [31:0]       mem_rsp_rdata
);
    localparam int DATA_W   = 32;
    localparam int IDX_W    = $clog2(DATA_W);
    localparam int WIN_BITS = 25;

    logic [ADDR_W-1:0] lat_addr;
    logic [2:0]        lat_size;
    logic              lat_bit;
    logic [IDX_W-1:0]  bit_idx;
    logic              sel_bit;
    logic [DATA_W-1:0] merged_unit;

    bb_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_valid     (req_valid),
        .req_ready     (req_ready),
        .req_write     (req_write),
        .req_addr      (req_addr),
        .req_size      (req_size),
        .req_wdata     (req_wdata),
        .rsp_valid     (rsp_valid),
        .rsp_err       (rsp_err),
        .rsp_rdata     (rsp_rdata),
        .mem_req_valid (mem_req_valid),
        .mem_req_ready (mem_req_ready),
        .mem_write     (mem_write),
        .mem_wdata     (mem_wdata),
        .mem_rsp_valid (mem_rsp_valid),
        .mem_rsp_err   (mem_rsp_err),
        .lat_addr      (lat_addr),
        .lat_size      (lat_size),
        .lat_bit       (lat_bit),
        .sel_bit       (sel_bit),
        .merged_unit   (merged_unit)
    );

    bb_addr_map #(
        .ADDR_W(ADDR_W), .WIN_BITS(WIN_BITS), .BASE_ADDR(BASE_ADDR), .IDX_W(IDX_W)
    ) u_map (
        .alias_addr (lat_addr),
        .acc_size   (lat_size),
        .back_addr  (mem_addr),
        .bit_idx    (bit_idx)
    );

    bb_bit_ops #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_bits (
        .unit_in  (mem_rsp_rdata),
        .bit_idx  (bit_idx),
        .acc_size (lat_size),
        .new_bit  (lat_bit),
        .bit_out  (sel_bit),
        .unit_out (merged_unit)
    );

    // Backing size follows the latched request size.
    assign mem_size = lat_size;

endmodule

// File: rtl/bitband_bridge_chk.sv
// Module: bitband_bridge_chk
// Protocol checker for the bit-band alias bridge, bound to the top module.
// Tracks which backing phase is outstanding so that error and write-back
// rules can be related to the port activity.
module bitband_bridge_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic [2:0]        req_size,
    input logic              rsp_valid,
    input logic              rsp_err,
    input logic [31:0]       rsp_rdata,
    input logic              mem_req_valid,
    input logic              mem_req_ready,
    input logic              mem_write,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [2:0]        mem_size,
    input logic [31:0]       mem_wdata,
    input logic              mem_rsp_valid,
    input logic              mem_rsp_err
);
    logic              rd_out;
    logic [ADDR_W-1:0] rd_addr;
    logic [2:0]        rd_size;

    // Remember the outstanding backing read and its address and size.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_out  <= 1'b0;
            rd_addr <= '0;
            rd_size <= 3'd0;
        end else begin
            if (mem_req_valid && mem_req_ready && !mem_write) begin
                rd_out  <= 1'b1;
                rd_addr <= mem_addr;
                rd_size <= mem_size;
            end else if (mem_rsp_valid) begin
                rd_out <= 1'b0;
            end
        end
    end

    // R1
    addr_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> ((mem_size == 3'd4) ? (mem_addr[1:0] == 2'b00) :
                           (mem_size == 3'd2) ? (mem_addr[0] == 1'b0) : 1'b1));

    // R3
    rdata_one_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_rdata[31:1] == 31'd0));

    // R4
    wb_same_unit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && mem_write) |-> (mem_addr == rd_addr && mem_size == rd_size));

    // R5
    rd_err_no_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_out && mem_rsp_valid && mem_rsp_err) |=> (!mem_req_valid && rsp_valid && rsp_err));

    // R7
    bad_size_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !(req_size == 3'd1 || req_size == 3'd2 || req_size == 3'd4))
        |=> (!mem_req_valid && rsp_valid && rsp_err));

    // R8
    busy_no_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid || rsp_valid) |-> !req_ready);

    // R8
    rsp_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    // R10
    hold_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=>
        (mem_req_valid && $stable(mem_addr) && $stable(mem_size) &&
         $stable(mem_write) && $stable(mem_wdata)));

endmodule

bind bitband_bridge bitband_bridge_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .req_size      (req_size),
    .rsp_valid     (rsp_valid),
    .rsp_err       (rsp_err),
    .rsp_rdata     (rsp_rdata),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_write     (mem_write),
    .mem_addr      (mem_addr),
    .mem_size      (mem_size),
    .mem_wdata     (mem_wdata),
    .mem_rsp_valid (mem_rsp_valid),
    .mem_rsp_err   (mem_rsp_err)
);

// File: tb/sim_bitband_bridge.sv
// Bench: sweeps alias words over a 64-byte backing model for every legal
// size, plus error, illegal-size, window-decode and stall cases.
module sim_bitband_bridge;
    localparam int          AW   = 32;
    localparam logic [31:0] BASE = 32'h2000_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [31:0] req_addr = '0;
    logic [2:0]  req_size = 3'd1;
    logic [31:0] req_wdata = '0;
    logic        rsp_valid, rsp_err;
    logic [31:0] rsp_rdata;
    logic        mem_req_valid, mem_write;
    logic        mem_req_ready;
    logic [31:0] mem_addr, mem_wdata;
    logic [2:0]  mem_size;
    logic        mem_rsp_valid = 1'b0;
    logic        mem_rsp_err = 1'b0;
    logic [31:0] mem_rsp_rdata = '0;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    bitband_bridge #(.ADDR_W(AW), .BASE_ADDR(BASE)) u0 (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_write(mem_write), .mem_addr(mem_addr), .mem_size(mem_size),
        .mem_wdata(mem_wdata), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_err(mem_rsp_err), .mem_rsp_rdata(mem_rsp_rdata)
    );

    // Backing memory model and its observation counters.
    logic [7:0]  mem [64];
    logic [7:0]  shadow [64];
    logic        inj_rd_err = 1'b0;
    logic        inj_wr_err = 1'b0;
    logic        stall_en = 1'b0;
    logic [1:0]  stall_cnt = '0;
    int          n_rd = 0;
    int          n_wr = 0;
    int          n_stall_held = 0;
    logic [31:0] last_rd_addr = '0;
    logic [2:0]  last_rd_size = '0;
    logic [31:0] last_wr_addr = '0;
    logic [2:0]  last_wr_size = '0;

    assign mem_req_ready = !stall_en || (stall_cnt == 2'd3);

    always @(posedge clk) begin
        stall_cnt     <= stall_cnt + 2'd1;
        mem_rsp_valid <= 1'b0;
        mem_rsp_err   <= 1'b0;
        if (mem_req_valid && !mem_req_ready) n_stall_held <= n_stall_held + 1;
        if (mem_req_valid && mem_req_ready) begin
            mem_rsp_valid <= 1'b1;
            if (!mem_write) begin
                logic [31:0] d;
                n_rd         <= n_rd + 1;
                last_rd_addr <= mem_addr;
                last_rd_size <= mem_size;
                d = '0;
                for (int k = 0; k < int'(mem_size); k++)
                    d[8*k +: 8] = mem[6'(mem_addr[5:0] + 6'(k))];
                mem_rsp_rdata <= d;
                mem_rsp_err   <= inj_rd_err;
            end else begin
                n_wr         <= n_wr + 1;
                last_wr_addr <= mem_addr;
                last_wr_size <= mem_size;
                mem_rsp_err  <= inj_wr_err;
                if (!inj_wr_err)
                    for (int k = 0; k < int'(mem_size); k++)
                        mem[6'(mem_addr[5:0] + 6'(k))] <= mem_wdata[8*k +: 8];
            end
        end
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    // One alias access; returns the response fields and busy-ready violations.
    task automatic access(input bit wr, input logic [31:0] a, input logic [2:0] sz,
                          input logic [31:0] wd, output bit err, output logic [31:0] rd,
                          output int ready_busy, output int rsp_cycles);
        int t;
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_size = sz; req_wdata = wd;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        ready_busy = 0; rsp_cycles = 0; t = 0;
        while (!rsp_valid && t < 60) begin
            if (req_ready) ready_busy++;
            @(negedge clk);
            t++;
        end
        err = rsp_err; rd = rsp_rdata;
        while (rsp_valid) begin
            rsp_cycles++;
            @(negedge clk);
        end
    endtask

    // Reference mapping computed from the requirements.
    function automatic logic [31:0] exp_addr(input logic [31:0] a, input int s);
        int off;
        off = int'(a[24:0]);
        return BASE | 32'(((off / 32) / s) * s);
    endfunction

    function automatic int exp_idx(input logic [31:0] a, input int s);
        return (int'(a[24:0]) / 4) % (8 * s);
    endfunction

    initial begin
        bit          e;
        logic [31:0] r;
        int          rb, rc, rd0, wr0, mism;
        logic [31:0] ea;
        int          ei, eb;

        for (int i = 0; i < 64; i++) begin
            mem[i]    = 8'((i * 53 + 17) ^ (i << 3));
            shadow[i] = mem[i];
        end
        repeat (3) @(negedge clk);
        // R9: reset state
        check(req_ready === 1'b1 && mem_req_valid === 1'b0 && rsp_valid === 1'b0,
              "R9 reset idle", {29'd0, req_ready, mem_req_valid, rsp_valid}, 32'h4);
        rst_n = 1'b1;

        // R1 R2 R3 R4: sweep sizes, alias words, reads and both write values
        for (int si = 0; si < 3; si++) begin
            int s;
            s = (si == 0) ? 1 : (si == 1) ? 2 : 4;
            for (int w = 0; w < 128; w++) begin
                logic [31:0] a;
                logic [7:0] pre [64];
                a  = ((w % 3 == 0) ? 32'h2200_0000 : (w % 3 == 1) ? 32'h4200_0000 : 32'hFE00_0000)
                     + 32'(w * 4);
                ea = exp_addr(a, s);
                ei = exp_idx(a, s);
                eb = int'(ea[5:0]) + ei / 8;
                rd0 = n_rd; wr0 = n_wr;
                access(1'b0, a, 3'(s), 32'hFFFF_FFFE, e, r, rb, rc);
                check(!e && r == {31'd0, shadow[eb][ei % 8]}, "R3 read bit value",
                      r, {31'd0, shadow[eb][ei % 8]});
                check(n_rd == rd0 + 1 && n_wr == wr0 && last_rd_addr == ea &&
                      last_rd_size == 3'(s), "R1 read address and size", last_rd_addr, ea);
                check(rb == 0 && rc == 1, "R8 busy and single response", rb * 16 + rc, 32'd1);
                for (int k = 0; k < 64; k++) pre[k] = shadow[k];
                // Write the inverse with noise in upper bits (R4 ignores them).
                shadow[eb][ei % 8] = ~pre[eb][ei % 8];
                rd0 = n_rd; wr0 = n_wr;
                access(1'b1, a, 3'(s), {31'h5A5A_A5A5 >> 1, ~pre[eb][ei % 8]}, e, r, rb, rc);
                mism = 0;
                for (int k = 0; k < 64; k++) if (mem[k] !== shadow[k]) mism++;
                check(!e && mism == 0 && n_rd == rd0 + 1 && n_wr == wr0 + 1 &&
                      last_wr_addr == ea && last_wr_size == 3'(s),
                      "R4 write-back unit", 32'(mism), 32'd0);
                check(rb == 0 && rc == 1, "R8 busy on write", rb * 16 + rc, 32'd1);
                check(r == 32'd0, "R2 write response data", r, 32'd0);
            end
        end

        // R1: top of the window and upper alias bits ignored
        access(1'b0, 32'h23FF_FFFC, 3'd4, '0, e, r, rb, rc);
        check(last_rd_addr == 32'h200F_FFFC, "R1 window top decode", last_rd_addr, 32'h200F_FFFC);
        access(1'b0, 32'h03FF_FFF0, 3'd1, '0, e, r, rb, rc);
        check(last_rd_addr == 32'h200F_FFFF, "R1 upper bits ignored", last_rd_addr, 32'h200F_FFFF);

        // R7: every illegal size errors with no backing access
        for (int sz = 0; sz < 8; sz++) begin
            if (sz == 1 || sz == 2 || sz == 4) continue;
            rd0 = n_rd; wr0 = n_wr;
            access(1'b1, 32'h2200_0040, 3'(sz), 32'h1, e, r, rb, rc);
            check(e && n_rd == rd0 && n_wr == wr0 && rc == 1, "R7 illegal size",
                  {31'd0, e}, 32'd1);
        end

        // R5: read error stops a write with no write-back and memory intact
        inj_rd_err = 1'b1;
        rd0 = n_rd; wr0 = n_wr;
        access(1'b1, 32'h2200_0000, 3'd4, 32'h1, e, r, rb, rc);
        mism = 0;
        for (int k = 0; k < 64; k++) if (mem[k] !== shadow[k]) mism++;
        check(e && n_rd == rd0 + 1 && n_wr == wr0 && mism == 0, "R5 read error no write-back",
              32'(n_wr - wr0), 32'd0);
        access(1'b0, 32'h2200_0004, 3'd2, '0, e, r, rb, rc);
        check(e == 1'b1, "R5 read error on alias read", {31'd0, e}, 32'd1);
        inj_rd_err = 1'b0;

        // R6: write-back error passed through, and a clean write-back reports none
        inj_wr_err = 1'b1;
        rd0 = n_rd; wr0 = n_wr;
        access(1'b1, 32'h2200_0008, 3'd1, 32'h1, e, r, rb, rc);
        check(e && n_wr == wr0 + 1, "R6 write-back error", {31'd0, e}, 32'd1);
        inj_wr_err = 1'b0;
        access(1'b1, 32'h2200_000C, 3'd1, 32'h0, e, r, rb, rc);
        shadow[0][3] = 1'b0;
        check(!e && mem[0] === shadow[0], "R6 clean write-back", {24'd0, mem[0]},
              {24'd0, shadow[0]});

        // R10: stalled backing port, requests held and results unchanged
        stall_en = 1'b1;
        access(1'b1, 32'h2200_0100, 3'd4, 32'h1, e, r, rb, rc);
        shadow[8][0] = 1'b1;
        access(1'b0, 32'h2200_0100, 3'd4, 32'h0, e, r, rb, rc);
        check(!e && r == 32'd1 && n_stall_held > 0 && mem[8] === shadow[8],
              "R10 stall hold", r, 32'd1);
        stall_en = 1'b0;

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=0x%08h expected=0x%08h", 32'd0, 32'd1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule